// File: doc/BRIEF.md
# Scanning Parallel-ADC Sequencer

This block runs an external eight-input successive-approximation converter that has a parallel byte output, and it reads the inputs one after another in a fixed rotation. From one fast system clock it makes two timing references. One is a square-wave conversion clock that is sent to the converter. The other is a slower scan tick, and each scan tick moves the rotation on to the next input. All sequencing logic stays in the system clock domain and moves forward on one-cycle clock enables.

Each scan period holds one sample, and a Moore sequencer with seven states runs it in a fixed order. The sequencer rests in an idle state and places the channel number on the address pins. It then raises the address strobe and pulses the start line. The falling edge of the start line launches the conversion. The sequencer waits for the synchronised end-of-conversion input, but it ignores that input for a short blanking window. It then opens the converter's output drivers and raises an internal capture pulse. The rising edge of that pulse stores the byte, together with its channel number, in an output register, and the sequencer then returns to idle. If end-of-conversion never arrives, a timeout ends the sample, and the block reports an error pulse in place of data.

Top module: `adc_scan_ctrl`

## Requirements
- R1: `adc_clk_o` is a square wave with a period of ADC_DIV system cycles. It is high for ADC_DIV/2 cycles of each period.
- R2: A scan tick fires every SCAN_DIV system cycles. Each tick moves the channel one step forward, counting 0 to 7 and then wrapping back to 0. After reset the first sample is taken on channel 0, and each later sample is taken on the next channel.
- R3: While `rst_i` is high and in the first cycle after it falls, the strobes, start, output enable, valid and timeout outputs are all low and `adc_addr_o` is 0. A reset applied in the middle of a sample ends that sample, and the next sample is taken on channel 0.
- R4: The address strobe is high for exactly one conversion-clock period. `adc_addr_o` holds its value through the strobe and the start pulse, and when the strobe rises it equals the channel of the current sample.
- R5: Start rises in the same cycle that the address strobe falls. Start stays high for one conversion-clock period. At most one of strobe, start and output enable is high at any time.
- R6: After start falls, end-of-conversion is ignored for the first EOC_BLANK conversion-clock periods. After that, the sequencer leaves the wait state only when the synchronised end-of-conversion input is high. A high level that is left over from before the conversion therefore cannot end the wait early.
- R7: Output enable rises only after the wait has ended, at least EOC_BLANK conversion-clock periods after start falls. It stays high for exactly two conversion-clock periods.
- R8: `sample_o` is {channel[2:0], data[7:0]}, with the channel in bits 10:8. The data byte is the value on `adc_data_i` while output enable is high. `sample_valid_o` goes high for one cycle for each completed sample.
- R9: If end-of-conversion has not been seen by EOC_TIMEOUT conversion-clock periods after start falls, `timeout_o` goes high for one cycle. In that case output enable is never raised and no valid strobe is produced. The next scan tick takes the following channel as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| adc_clk_o | output | 1 | Conversion clock sent to the converter |
| adc_addr_o | output | 3 | Channel address pins |
| adc_ale_o | output | 1 | Address strobe, active high |
| adc_start_o | output | 1 | Start pulse; the conversion begins on its falling edge |
| adc_oe_o | output | 1 | Converter output-drive enable, active high |
| adc_eoc_i | input | 1 | End of conversion, asynchronous; high means the conversion is done |
| adc_data_i | input | 8 | Converter data bus |
| sample_o | output | 11 | Captured channel and data |
| sample_valid_o | output | 1 | One-cycle strobe for a new sample |
| timeout_o | output | 1 | One-cycle strobe when a conversion fails to finish |

## Verification
The bound checker tests the following on every cycle. Strobe, start and output enable are never high together. The address holds while strobe and start are high. Start rises only after the strobe. A valid strobe comes only directly after output enable. The valid and timeout pulses each last a single cycle. The bench scenarios are needed for everything that depends on the converter's response. These include the channel rotation and its wrap, the exact pulse widths measured in conversion-clock periods, the rejection of a late-falling end-of-conversion, the data actually captured, the timeout path, and recovery from a reset applied in the middle of a sample.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_STROBE = 3'd1,
    SEQ_KICK  = 3'd2,
    SEQ_WAIT  = 3'd3,
    SEQ_DRIVE = 3'd4,
    SEQ_GRAB  = 3'd5,
    SEQ_DONE  = 3'd6
  } seq_state_t;

endpackage

// File: rtl/adc_scan_timebase.sv
module adc_scan_timebase #(
  parameter int ADC_DIV  = 40,
  parameter int SCAN_DIV = 500
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic adc_clk_o,
  output logic adc_en_o,
  output logic scan_tick_o
);

  localparam int AW   = $clog2(ADC_DIV);
  localparam int SW   = $clog2(SCAN_DIV);
  localparam int HALF = ADC_DIV / 2;

  logic [AW-1:0] adc_cnt, adc_cnt_nxt;
  logic [SW-1:0] scan_cnt, scan_cnt_nxt;

  always_comb begin
    adc_cnt_nxt  = (adc_cnt == AW'(ADC_DIV - 1)) ? '0 : adc_cnt + 1'b1;
    scan_cnt_nxt = (scan_cnt == SW'(SCAN_DIV - 1)) ? '0 : scan_cnt + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      adc_cnt     <= '0;
      scan_cnt    <= '0;
      adc_clk_o   <= 1'b0;
      adc_en_o    <= 1'b0;
      scan_tick_o <= 1'b0;
    end else begin
      adc_cnt     <= adc_cnt_nxt;
      scan_cnt    <= scan_cnt_nxt;
      adc_clk_o   <= (adc_cnt_nxt < AW'(HALF));
      adc_en_o    <= (adc_cnt_nxt == AW'(ADC_DIV - 1));
      scan_tick_o <= (scan_cnt_nxt == SW'(SCAN_DIV - 1));
    end
  end

endmodule

// File: rtl/adc_eoc_sync.sv
module adc_eoc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk_i) begin
    if (rst_i) chain <= '0;
    else       chain <= {chain[STAGES-2:0], async_i};
  end

  assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int CH_W        = 3,
  parameter int EOC_BLANK   = 2,
  parameter int EOC_TIMEOUT = 6
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            adc_en_i,
  input  logic            scan_tick_i,
  input  logic            eoc_i,
  output logic [CH_W-1:0] chan_o,
  output logic            ale_o,
  output logic            start_o,
  output logic            oe_o,
  output logic            lock_o,
  output logic            timeout_o
);

  localparam int WW = $clog2(EOC_TIMEOUT + 1);

  seq_state_t    state_q, state_d;
  logic [WW-1:0] wait_q, wait_d;
  logic          pend_q;
  logic          to_d;

  always_comb begin
    state_d = state_q;
    wait_d  = wait_q;
    to_d    = 1'b0;
    if (adc_en_i) begin
      unique case (state_q)
        SEQ_IDLE:   if (pend_q) state_d = SEQ_STROBE;
        SEQ_STROBE: state_d = SEQ_KICK;
        SEQ_KICK: begin
          state_d = SEQ_WAIT;
          wait_d  = '0;
        end
        SEQ_WAIT: begin
          if (wait_q >= WW'(EOC_BLANK) && eoc_i) begin
            state_d = SEQ_DRIVE;
          end else if (wait_q == WW'(EOC_TIMEOUT - 1)) begin
            state_d = SEQ_DONE;
            to_d    = 1'b1;
          end else begin
            wait_d = wait_q + 1'b1;
          end
        end
        SEQ_DRIVE: state_d = SEQ_GRAB;
        SEQ_GRAB:  state_d = SEQ_DONE;
        SEQ_DONE:  state_d = SEQ_IDLE;
        default:   state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q   <= SEQ_IDLE;
      wait_q    <= '0;
      pend_q    <= 1'b1;
      chan_o    <= '0;
      ale_o     <= 1'b0;
      start_o   <= 1'b0;
      oe_o      <= 1'b0;
      lock_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      wait_q    <= wait_d;
      if (scan_tick_i) begin
        pend_q <= 1'b1;
        chan_o <= chan_o + 1'b1;
      end else if (state_q == SEQ_IDLE && state_d == SEQ_STROBE) begin
        pend_q <= 1'b0;
      end
      ale_o     <= (state_d == SEQ_STROBE);
      start_o   <= (state_d == SEQ_KICK);
      oe_o      <= (state_d == SEQ_DRIVE) || (state_d == SEQ_GRAB);
      lock_o    <= (state_d == SEQ_GRAB);
      timeout_o <= to_d;
    end
  end

endmodule

// File: rtl/adc_sample_latch.sv
module adc_sample_latch #(
  parameter int CH_W = 3,
  parameter int D_W  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 lock_i,
  input  logic [CH_W-1:0]      chan_i,
  input  logic [D_W-1:0]       data_i,
  output logic [CH_W+D_W-1:0]  sample_o,
  output logic                 valid_o
);

  logic lock_prev;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      lock_prev <= 1'b0;
      sample_o  <= '0;
      valid_o   <= 1'b0;
    end else begin
      lock_prev <= lock_i;
      valid_o   <= lock_i && !lock_prev;
      if (lock_i && !lock_prev) sample_o <= {chan_i, data_i};
    end
  end

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
  parameter int ADC_DIV     = 40,
  parameter int SCAN_DIV    = 500,
  parameter int EOC_BLANK   = 2,
  parameter int EOC_TIMEOUT = 6,
  parameter int SYNC_STAGES = 2,
  parameter int CH_W        = 3,
  parameter int D_W         = 8
) (
  input  logic                clk_i,
  input  logic                rst_i,
  output logic                adc_clk_o,
  output logic [CH_W-1:0]     adc_addr_o,
  output logic                adc_ale_o,
  output logic                adc_start_o,
  output logic                adc_oe_o,
  input  logic                adc_eoc_i,
  input  logic [D_W-1:0]      adc_data_i,
  output logic [CH_W+D_W-1:0] sample_o,
  output logic                sample_valid_o,
  output logic                timeout_o
);

  logic adc_en, scan_tick, eoc_s, lock;

  adc_scan_timebase #(.ADC_DIV(ADC_DIV), .SCAN_DIV(SCAN_DIV)) u_tb (
    .clk_i(clk_i), .rst_i(rst_i), .adc_clk_o(adc_clk_o),
    .adc_en_o(adc_en), .scan_tick_o(scan_tick)
  );

  adc_eoc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i), .async_i(adc_eoc_i), .sync_o(eoc_s)
  );

  adc_scan_fsm #(.CH_W(CH_W), .EOC_BLANK(EOC_BLANK), .EOC_TIMEOUT(EOC_TIMEOUT)) u_fsm (
    .clk_i(clk_i), .rst_i(rst_i), .adc_en_i(adc_en), .scan_tick_i(scan_tick),
    .eoc_i(eoc_s), .chan_o(adc_addr_o), .ale_o(adc_ale_o), .start_o(adc_start_o),
    .oe_o(adc_oe_o), .lock_o(lock), .timeout_o(timeout_o)
  );

  adc_sample_latch #(.CH_W(CH_W), .D_W(D_W)) u_latch (
    .clk_i(clk_i), .rst_i(rst_i), .lock_i(lock), .chan_i(adc_addr_o),
    .data_i(adc_data_i), .sample_o(sample_o), .valid_o(sample_valid_o)
  );

endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk #(
  parameter int CH_W = 3,
  parameter int D_W  = 8
) (
  input logic                clk_i,
  input logic                rst_i,
  input logic [CH_W-1:0]     adc_addr_o,
  input logic                adc_ale_o,
  input logic                adc_start_o,
  input logic                adc_oe_o,
  input logic [CH_W+D_W-1:0] sample_o,
  input logic                sample_valid_o,
  input logic                timeout_o
);

  // R5
  ctl_exclusive_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({adc_ale_o, adc_start_o, adc_oe_o}));

  // R4
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (adc_ale_o || adc_start_o) |-> $stable(adc_addr_o));

  // R5
  start_follows_ale_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(adc_start_o) |-> $past(adc_ale_o));

  // R8
  valid_after_oe_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    sample_valid_o |-> $past(adc_oe_o));

  // R8
  valid_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    sample_valid_o |=> !sample_valid_o);

  // R9
  timeout_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    timeout_o |=> !timeout_o);

  // R9
  timeout_no_read_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    timeout_o |-> (!adc_oe_o && !sample_valid_o));

endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(.CH_W(CH_W), .D_W(D_W)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .adc_addr_o(adc_addr_o), .adc_ale_o(adc_ale_o),
  .adc_start_o(adc_start_o), .adc_oe_o(adc_oe_o), .sample_o(sample_o),
  .sample_valid_o(sample_valid_o), .timeout_o(timeout_o)
);

// File: tb/adc_scan_ctrl_test.sv
module adc_scan_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADC_DIV    = 40;
  localparam int SCAN_DIV   = 500;
  localparam int BLANK      = 2;
  localparam int TMO        = 6;
  localparam int CONV_LEN   = 100;
  localparam int LATE_LEN   = 60;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adc_clk, ale, start, oe, valid, tmo;
  logic [2:0]  addr;
  logic [10:0] sample;
  logic        eoc = 1'b1;
  logic [7:0]  result = 8'h00;
  logic [7:0]  bus;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int mode = 0;
  int exp_ch = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_scan_ctrl uut (
    .clk_i(clk), .rst_i(rst), .adc_clk_o(adc_clk), .adc_addr_o(addr),
    .adc_ale_o(ale), .adc_start_o(start), .adc_oe_o(oe), .adc_eoc_i(eoc),
    .adc_data_i(bus), .sample_o(sample), .sample_valid_o(valid), .timeout_o(tmo)
  );

  // converter model: drives the bus only while enabled, junk otherwise
  assign bus = oe ? result : ~result;

  logic       ale_q = 1'b0, start_q = 1'b0, oe_q = 1'b0;
  logic [2:0] latched = 3'd0;
  bit         busy = 1'b0;
  int         conv_t = 0, res_n = 0, oe_rises = 0;
  int         t_ale_r = 0, t_ale_f = 0, t_st_r = 0, t_st_f = 0, t_oe_r = 0, t_oe_f = 0;
  logic [2:0] addr_at_ale = 3'd0;

  always @(negedge clk) begin
    if (ale && !ale_q) begin latched = addr; addr_at_ale = addr; t_ale_r = cyc; end
    if (!ale && ale_q) t_ale_f = cyc;
    if (start && !start_q) t_st_r = cyc;
    if (oe && !oe_q) begin t_oe_r = cyc; oe_rises++; end
    if (!oe && oe_q) t_oe_f = cyc;
    if (!start && start_q) begin
      t_st_f = cyc; busy = 1'b1; conv_t = 0; eoc = (mode == 1);
    end else if (busy) begin
      conv_t++;
      if (mode == 1 && conv_t == LATE_LEN) eoc = 1'b0;
      if (conv_t == CONV_LEN && mode != 2) begin
        eoc = 1'b1; busy = 1'b0; res_n++;
        result = {latched, res_n[4:0]};
      end
    end
    ale_q = ale; start_q = start; oe_q = oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 1 = valid sample, 2 = timeout, 0 = nothing within limit
  task automatic wait_event(output int kind);
    kind = 0;
    for (int i = 0; i < 3000 && kind == 0; i++) begin
      @(negedge clk);
      if (valid) kind = 1;
      else if (tmo) kind = 2;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(!ale && !start && !oe && !valid && !tmo, "R3 outputs low in reset", {ale, start, oe, valid, tmo}, 0);
    chk(addr == 3'd0, "R3 addr in reset", addr, 0);
    @(posedge clk); rst = 1'b0;
    @(negedge clk);
    chk(!ale && !start && !oe && !valid, "R3 outputs low after reset", {ale, start, oe, valid}, 0);
    chk(addr == 3'd0, "R3 addr after reset", addr, 0);
    exp_ch = 0;
  endtask

  task automatic test_clock();
    int t0, t1, t2;
    @(posedge adc_clk); t0 = cyc;
    @(negedge adc_clk); t1 = cyc;
    @(posedge adc_clk); t2 = cyc;
    chk(t1 - t0 == ADC_DIV / 2, "R1 clock high time", t1 - t0, ADC_DIV / 2);
    chk(t2 - t0 == ADC_DIV, "R1 clock period", t2 - t0, ADC_DIV);
  endtask

  task automatic one_sample(input string tag);
    int kind;
    wait_event(kind);
    chk(kind == 1, {tag, " R8 valid seen"}, kind, 1);
    chk(sample[10:8] == 3'(exp_ch), {tag, " R2 channel order"}, sample[10:8], exp_ch);
    chk(sample[7:0] == result, {tag, " R8 data byte"}, sample[7:0], result);
    chk(addr_at_ale == 3'(exp_ch), {tag, " R4 addr at strobe"}, addr_at_ale, exp_ch);
    chk(t_ale_f - t_ale_r == ADC_DIV, {tag, " R4 strobe width"}, t_ale_f - t_ale_r, ADC_DIV);
    chk(t_st_r == t_ale_f && t_st_f - t_st_r == ADC_DIV, {tag, " R5 start timing"},
        t_st_f - t_st_r, ADC_DIV);
    chk(t_oe_r - t_st_f >= BLANK * ADC_DIV, {tag, " R7 enable after blank"},
        t_oe_r - t_st_f, BLANK * ADC_DIV);
    repeat (2 * ADC_DIV) @(negedge clk);
    chk(t_oe_f - t_oe_r == 2 * ADC_DIV, {tag, " R7 enable width"}, t_oe_f - t_oe_r, 2 * ADC_DIV);
    exp_ch = (exp_ch + 1) % 8;
  endtask

  task automatic test_sweep();
    for (int i = 0; i < 9; i++) one_sample("sweep R2");
  endtask

  task automatic test_blank();
    logic [7:0] old;
    old = result;
    mode = 1;
    one_sample("late-eoc R6");
    chk(sample[7:0] != old, "R6 stale byte rejected", sample[7:0], result);
    mode = 0;
  endtask

  task automatic test_timeout();
    int kind, rises;
    rises = oe_rises;
    mode = 2;
    wait_event(kind);
    chk(kind == 2, "R9 timeout pulse", kind, 2);
    @(negedge clk);
    chk(!tmo, "R9 timeout one cycle", tmo, 0);
    chk(oe_rises == rises, "R9 no output enable", oe_rises - rises, 0);
    mode = 0;
    exp_ch = (exp_ch + 1) % 8;
    one_sample("after-timeout R9");
  endtask

  task automatic test_midreset();
    @(negedge start);
    repeat (30) @(negedge clk);
    do_reset();
    one_sample("mid-reset R3");
  endtask

  initial begin
    do_reset();
    test_clock();
    test_sweep();
    test_blank();
    test_timeout();
    test_midreset();
    one_sample("final R2");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule